// File: doc/BRIEF.md
# Power-Management Event Controller

This block gathers system power events and turns them into two interrupt-style requests for the processor: a system-management request (SMI) and a system-control request (SCI). It watches four external pins: lid switch, thermal alarm, power button (active low) and battery-low. Each pin is brought into the clock domain by a multi-stage synchronizer. A detector then applies the edge polarity or level mode chosen in the control register. Every detected event sets a status bit, and status bits stay set until software clears them.

Software reaches the block through a small register port with four word addresses: a 16-bit control word, a 6-bit status word, a 6-bit enable word and an 8-bit command port. The SMI output is raised for enabled lid, thermal, button and software-command events, and only while the master SMI enable is on. The SCI output is raised for enabled battery-low and global-release events. An optional lock marks each SMI as in service. While the lock is on, later SMIs are held off until software acknowledges the active one. A release handshake lets legacy code hand control back by setting a global status bit. Two control bits drive the drive-bus power-off lines directly.

Top module: `pm_event_ctl`

## Requirements
- R1: After reset the control word (address 0) reads 0x0010, meaning only the lock bit 4 is set. Status (address 1), enable (address 2) and command (address 3) read 0, and `smi_out`, `sci_out`, `resume_req`, `drv_pri_off` and `drv_sec_off` are all low.
- R2: Control bits 11, 10, 7, 6, 5, 4, 2 and 0 read back what was last written to them. Bits 15:12 and 9 always read 0.
- R3: Control bit 7 sets the lid polarity and bit 6 sets the thermal polarity: 0 means a rising edge, 1 means a falling edge. A matching edge sets status bit 0 (lid) or bit 1 (thermal). The opposite edge sets nothing.
- R4: With control bit 2 at 0, a rising edge of `pwr_btn_n` (button release) sets status bit 2 and a falling edge does not. With bit 2 at 1, status bit 2 is set on every cycle that the synchronized pin is low, so a clear while the button is held does not last.
- R5: A rising edge of `batt_low` sets status bit 3. `resume_req` follows the synchronized `batt_low` level, but is forced low while control bit 5 is 1.
- R6: Status bits are write-one-to-clear. A 0 in a written bit leaves that bit unchanged. If an event and a clear hit the same bit in the same cycle, the event wins.
- R7: While control bit 0 (the SMI enable) is 0, `smi_out` stays low whatever the status and enable words hold.
- R8: With control bit 0 set, `smi_out` rises when any of status bits 0, 1, 2 or 4 is set together with the matching enable bit, and falls once none remains.
- R9: Control bit 8 reads 1 once an SMI has been raised, and writing a 1 to it clears it. While lock bit 4 is set and bit 8 is 1, a new SMI request is held off. After the acknowledge write, a pending request raises `smi_out` again.
- R10: With lock bit 4 at 0, a pending request raises `smi_out` even when bit 8 is still 1.
- R11: Writing 1 to control bit 1 (release) sets bit 1 and status bit 5. Writing 0 to bit 1 has no effect. Clearing status bit 5 also clears bit 1. `sci_out` is high while status bit 3 or 5 is set with its enable bit.
- R12: Any write to address 3 stores the byte, which then reads back there, and sets status bit 4.
- R13: `drv_sec_off` equals control bit 11 and `drv_pri_off` equals control bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 enable, 3 command |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| lid_in | input | 1 | Lid switch pin, asynchronous |
| thrm_in | input | 1 | Thermal alarm pin, asynchronous |
| pwr_btn_n | input | 1 | Power button pin, low while pressed |
| batt_low | input | 1 | Battery-low pin, high when low |
| smi_out | output | 1 | SMI request level |
| sci_out | output | 1 | SCI request level |
| resume_req | output | 1 | Battery-driven resume request |
| drv_pri_off | output | 1 | Primary drive bus power-off |
| drv_sec_off | output | 1 | Secondary drive bus power-off |

## Verification
The event detectors are driven through every combination of source, polarity setting and edge direction, so a swapped polarity bit or a missing edge term shows up at once. The power button is tried with press and release in both modes, including a clear while the button is still held, which separates level detection from edge detection. The SMI path is run with the master enable off and on, with the lock on and off, and before and after an acknowledge. This separates gating by the enable from gating by the lock. Control and command words are swept with several bit patterns to expose stuck, reserved or mis-masked bits.

// File: rtl/pmev_pkg.sv
package pmev_pkg;
  localparam int CTL_W  = 16;
  localparam int STS_W  = 6;
  localparam int CMD_W  = 8;
  localparam int EVT_N  = 4;

  // register selects
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_STS = 2'd1;
  localparam logic [1:0] SEL_EN  = 2'd2;
  localparam logic [1:0] SEL_CMD = 2'd3;

  // status / enable bit positions
  localparam int ST_LID   = 0;
  localparam int ST_THRM  = 1;
  localparam int ST_PBTN  = 2;
  localparam int ST_BATL  = 3;
  localparam int ST_SWSMI = 4;
  localparam int ST_GBL   = 5;

  // control bit positions
  localparam int CB_SMI_EN   = 0;
  localparam int CB_RELEASE  = 1;
  localparam int CB_PB_LEVEL = 2;
  localparam int CB_LOCK     = 4;
  localparam int CB_BL_NORES = 5;
  localparam int CB_THRM_FAL = 6;
  localparam int CB_LID_FAL  = 7;
  localparam int CB_IN_SMI   = 8;
  localparam int CB_PRI_OFF  = 10;
  localparam int CB_SEC_OFF  = 11;

  localparam logic [CTL_W-1:0] CTL_RW_MASK = 16'h0CF5;
  localparam logic [CTL_W-1:0] CTL_RST     = 16'h0010;
  localparam logic [STS_W-1:0] SMI_SRC     = 6'b010111;
  localparam logic [STS_W-1:0] SCI_SRC     = 6'b101000;

  function automatic logic edge_hit(input logic prev, input logic cur, input logic fall_sel);
    return fall_sel ? (prev & ~cur) : (~prev & cur);
  endfunction

  function automatic logic button_hit(input logic prev, input logic cur, input logic level_sel);
    return level_sel ? ~cur : (~prev & cur);
  endfunction

  function automatic logic [CTL_W-1:0] ctl_merge(input logic [CTL_W-1:0] old_v,
                                                 input logic [CTL_W-1:0] wr_v);
    return (old_v & ~CTL_RW_MASK) | (wr_v & CTL_RW_MASK);
  endfunction

  function automatic logic [STS_W-1:0] w1c_apply(input logic [STS_W-1:0] cur,
                                                 input logic [STS_W-1:0] clr,
                                                 input logic [STS_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/pmev_sync.sv
module pmev_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmev_detect.sv
module pmev_detect
  import pmev_pkg::*;
#(
  parameter logic [EVT_N-1:0] IDLE = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] lvl,
  input  logic             lid_fall,
  input  logic             thrm_fall,
  input  logic             pb_level,
  output logic [EVT_N-1:0] hit
);
  logic [EVT_N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= lvl;
  end

  always_comb begin
    hit[ST_LID]  = edge_hit(prev[ST_LID], lvl[ST_LID], lid_fall);
    hit[ST_THRM] = edge_hit(prev[ST_THRM], lvl[ST_THRM], thrm_fall);
    hit[ST_PBTN] = button_hit(prev[ST_PBTN], lvl[ST_PBTN], pb_level);
    hit[ST_BATL] = edge_hit(prev[ST_BATL], lvl[ST_BATL], 1'b0);
  end
endmodule

// File: rtl/pmev_smi_gate.sv
module pmev_smi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic lock,
  input  logic ack,
  output logic smi_q,
  output logic in_smi,
  output logic fire
);
  logic smi_nxt;

  always_comb begin
    smi_nxt = req & (smi_q | ~(lock & in_smi));
    fire    = smi_nxt & ~smi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_q  <= 1'b0;
      in_smi <= 1'b0;
    end else begin
      smi_q <= smi_nxt;
      if (fire)     in_smi <= 1'b1;
      else if (ack) in_smi <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_event_ctl.sv
module pm_event_ctl
  import pmev_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [CTL_W-1:0]  bus_wdata,
  output logic [CTL_W-1:0]  bus_rdata,
  input  logic              lid_in,
  input  logic              thrm_in,
  input  logic              pwr_btn_n,
  input  logic              batt_low,
  output logic              smi_out,
  output logic              sci_out,
  output logic              resume_req,
  output logic              drv_pri_off,
  output logic              drv_sec_off
);
  localparam logic [EVT_N-1:0] PIN_IDLE = 4'b0100;

  logic [CTL_W-1:0] ctl_q;
  logic [STS_W-1:0] sts_q, en_q;
  logic [CMD_W-1:0] cmd_q;
  logic             release_q, sci_q, resume_q;

  // named internal events
  logic             wr_ctl, wr_sts, wr_en, wr_cmd;
  logic [EVT_N-1:0] pins, lvl, evt_hit;
  logic             gbl_set, gbl_clr, smi_ack, smi_req, sci_req;
  logic             in_smi, smi_fire;
  logic [STS_W-1:0] sts_set;

  assign wr_ctl = bus_wr && (bus_addr == SEL_CTL);
  assign wr_sts = bus_wr && (bus_addr == SEL_STS);
  assign wr_en  = bus_wr && (bus_addr == SEL_EN);
  assign wr_cmd = bus_wr && (bus_addr == SEL_CMD);

  assign pins = {batt_low, pwr_btn_n, thrm_in, lid_in};

  for (genvar gi = 0; gi < EVT_N; gi++) begin : g_sync
    pmev_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE[gi])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins[gi]), .q(lvl[gi])
    );
  end

  pmev_detect #(.IDLE(PIN_IDLE)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl),
    .lid_fall(ctl_q[CB_LID_FAL]), .thrm_fall(ctl_q[CB_THRM_FAL]),
    .pb_level(ctl_q[CB_PB_LEVEL]), .hit(evt_hit)
  );

  assign gbl_set = wr_ctl && bus_wdata[CB_RELEASE];
  assign gbl_clr = wr_sts && bus_wdata[ST_GBL];
  assign smi_ack = wr_ctl && bus_wdata[CB_IN_SMI];
  assign sts_set = {gbl_set, wr_cmd, evt_hit};

  assign smi_req = ctl_q[CB_SMI_EN] && |(sts_q & en_q & SMI_SRC);
  assign sci_req = |(sts_q & en_q & SCI_SRC);

  pmev_smi_gate u_gate (
    .clk(clk), .rst_n(rst_n), .req(smi_req), .lock(ctl_q[CB_LOCK]),
    .ack(smi_ack), .smi_q(smi_out), .in_smi(in_smi), .fire(smi_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= CTL_RST;
      sts_q     <= '0;
      en_q      <= '0;
      cmd_q     <= '0;
      release_q <= 1'b0;
      sci_q     <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_merge(ctl_q, bus_wdata);
      if (wr_en)  en_q  <= bus_wdata[STS_W-1:0];
      if (wr_cmd) cmd_q <= bus_wdata[CMD_W-1:0];
      sts_q <= w1c_apply(sts_q, wr_sts ? bus_wdata[STS_W-1:0] : '0, sts_set);
      if (gbl_set)      release_q <= 1'b1;
      else if (gbl_clr) release_q <= 1'b0;
      sci_q    <= sci_req;
      resume_q <= lvl[ST_BATL] && !ctl_q[CB_BL_NORES];
    end
  end

  always_comb begin
    unique case (bus_addr)
      SEL_CTL: bus_rdata = ctl_q | ({{(CTL_W-1){1'b0}}, in_smi} << CB_IN_SMI)
                                 | ({{(CTL_W-1){1'b0}}, release_q} << CB_RELEASE);
      SEL_STS: bus_rdata = {{(CTL_W-STS_W){1'b0}}, sts_q};
      SEL_EN:  bus_rdata = {{(CTL_W-STS_W){1'b0}}, en_q};
      default: bus_rdata = {{(CTL_W-CMD_W){1'b0}}, cmd_q};
    endcase
  end

  assign sci_out     = sci_q;
  assign resume_req  = resume_q;
  assign drv_pri_off = ctl_q[CB_PRI_OFF];
  assign drv_sec_off = ctl_q[CB_SEC_OFF];
endmodule

// File: rtl/pmev_checker.sv
module pmev_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [15:0] ctl_q,
  input logic [5:0]  sts_q,
  input logic        release_q,
  input logic        in_smi,
  input logic        smi_req,
  input logic        smi_out
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[15:12] == 4'd0 && !bus_rdata[9]));

  assert_w1c_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd1) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_smi_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |=> !smi_out);

  assert_smi_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && (!ctl_q[4] || !in_smi || smi_out)) |=> smi_out);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[4] && in_smi && !smi_out) |=> !smi_out);

  assert_release_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_q) |-> sts_q[5]);

  assert_release_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_q[5]) |-> !release_q);

  assert_cmd_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> sts_q[4]);
endmodule

bind pm_event_ctl pmev_checker chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_q(ctl_q), .sts_q(sts_q),
  .release_q(release_q), .in_smi(in_smi), .smi_req(smi_req), .smi_out(smi_out)
);

// File: tb/pm_event_ctl_tb_top.sv
module pm_event_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        lid_in = 1'b0, thrm_in = 1'b0, pwr_btn_n = 1'b1, batt_low = 1'b0;
  logic        smi_out, sci_out, resume_req, drv_pri_off, drv_sec_off;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pm_event_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lid_in(lid_in),
    .thrm_in(thrm_in), .pwr_btn_n(pwr_btn_n), .batt_low(batt_low),
    .smi_out(smi_out), .sci_out(sci_out), .resume_req(resume_req),
    .drv_pri_off(drv_pri_off), .drv_sec_off(drv_sec_off)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pin(input int which, input logic v);
    @(negedge clk);
    case (which)
      0: lid_in = v;
      1: thrm_in = v;
      2: pwr_btn_n = v;
      default: batt_low = v;
    endcase
    step(6);
  endtask

  initial begin
    logic [15:0] r;
    logic [15:0] pats [6] = '{16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A, 16'h0CF5, 16'hF30A};
    logic [7:0]  cmds [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    rd(2'd0, r); chk("R1 ctl", r, 16'h0010);
    rd(2'd1, r); chk("R1 sts", r, 16'h0000);
    rd(2'd2, r); chk("R1 en", r, 16'h0000);
    rd(2'd3, r); chk("R1 cmd", r, 16'h0000);
    chk("R1 outs", {11'd0, smi_out, sci_out, resume_req, drv_pri_off, drv_sec_off}, 16'h0000);

    // R2 / R13 control sweep (release and ack bits kept 0)
    foreach (pats[i]) begin
      logic [15:0] w;
      w = pats[i] & ~16'h0102;
      wr(2'd0, w);
      rd(2'd0, r); chk("R2 ctl readback", r, w & 16'h0CF5);
      chk("R13 drive off", {14'd0, drv_sec_off, drv_pri_off}, {14'd0, w[11], w[10]});
    end
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h003F);

    // R3 polarity sweep over lid and thermal
    for (int src = 0; src < 2; src++) begin
      for (int pol = 0; pol < 2; pol++) begin
        wr(2'd0, pol ? (src ? 16'h0040 : 16'h0080) : 16'h0000);
        wr(2'd1, 16'h003F);
        set_pin(src, 1'b1);
        rd(2'd1, r); chk("R3 rise", {15'd0, r[src]}, {15'd0, (pol == 0)});
        wr(2'd1, 16'h003F);
        set_pin(src, 1'b0);
        rd(2'd1, r); chk("R3 fall", {15'd0, r[src]}, {15'd0, (pol == 1)});
      end
    end
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h003F);

    // R4 power button modes
    set_pin(2, 1'b0);
    rd(2'd1, r); chk("R4 edge press", {15'd0, r[2]}, 16'd0);
    set_pin(2, 1'b1);
    rd(2'd1, r); chk("R4 edge release", {15'd0, r[2]}, 16'd1);
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'h0004);
    step(4);
    rd(2'd1, r); chk("R4 level idle", {15'd0, r[2]}, 16'd0);
    set_pin(2, 1'b0);
    rd(2'd1, r); chk("R4 level held", {15'd0, r[2]}, 16'd1);
    wr(2'd1, 16'h0004);
    step(2);
    rd(2'd1, r); chk("R4 level reassert", {15'd0, r[2]}, 16'd1);
    set_pin(2, 1'b1);
    wr(2'd1, 16'h0004);
    step(3);
    rd(2'd1, r); chk("R4 level released", {15'd0, r[2]}, 16'd0);
    wr(2'd0, 16'h0000);

    // R6 write-one-to-clear
    set_pin(0, 1'b1);
    set_pin(1, 1'b1);
    wr(2'd1, 16'h0000);
    rd(2'd1, r); chk("R6 zero write", r, 16'h0003);
    wr(2'd1, 16'h0001);
    rd(2'd1, r); chk("R6 clear lid", r, 16'h0002);
    wr(2'd1, 16'h0002);
    rd(2'd1, r); chk("R6 clear thrm", r, 16'h0000);
    set_pin(0, 1'b0);
    set_pin(1, 1'b0);

    // R5 battery low
    wr(2'd2, 16'h0008);
    set_pin(3, 1'b1);
    rd(2'd1, r); chk("R5 status", {15'd0, r[3]}, 16'd1);
    chk("R5 resume", {15'd0, resume_req}, 16'd1);
    chk("R11 sci batlow", {15'd0, sci_out}, 16'd1);
    wr(2'd0, 16'h0020);
    step(3);
    chk("R5 resume blocked", {15'd0, resume_req}, 16'd0);
    set_pin(3, 1'b0);
    wr(2'd1, 16'h003F);
    step(3);
    chk("R11 sci clear", {15'd0, sci_out}, 16'd0);
    wr(2'd0, 16'h0000);

    // R7 / R8 SMI enable
    wr(2'd2, 16'h0001);
    set_pin(0, 1'b1);
    chk("R7 smi gated", {15'd0, smi_out}, 16'd0);
    wr(2'd0, 16'h0001);
    step(3);
    chk("R8 smi raised", {15'd0, smi_out}, 16'd1);
    wr(2'd1, 16'h0001);
    step(3);
    chk("R8 smi dropped", {15'd0, smi_out}, 16'd0);
    set_pin(0, 1'b0);
    wr(2'd0, 16'h0101);

    // R9 lock
    wr(2'd0, 16'h0011);
    set_pin(0, 1'b1);
    chk("R9 first smi", {15'd0, smi_out}, 16'd1);
    rd(2'd0, r); chk("R9 in-smi set", {15'd0, r[8]}, 16'd1);
    wr(2'd1, 16'h0001);
    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    rd(2'd1, r); chk("R9 pending", {15'd0, r[0]}, 16'd1);
    chk("R9 held off", {15'd0, smi_out}, 16'd0);
    wr(2'd0, 16'h0111);
    step(3);
    chk("R9 after ack", {15'd0, smi_out}, 16'd1);

    // R10 no lock
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0101);
    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    chk("R10 smi", {15'd0, smi_out}, 16'd1);
    wr(2'd1, 16'h0001);
    set_pin(0, 1'b0);
    rd(2'd0, r); chk("R10 in-smi still set", {15'd0, r[8]}, 16'd1);
    set_pin(0, 1'b1);
    chk("R10 smi not gated", {15'd0, smi_out}, 16'd1);
    wr(2'd1, 16'h003F);
    wr(2'd0, 16'h0100);
    set_pin(0, 1'b0);

    // R11 release handshake
    wr(2'd2, 16'h0020);
    wr(2'd0, 16'h0002);
    step(2);
    rd(2'd0, r); chk("R11 release bit", {15'd0, r[1]}, 16'd1);
    rd(2'd1, r); chk("R11 gbl status", {15'd0, r[5]}, 16'd1);
    chk("R11 sci", {15'd0, sci_out}, 16'd1);
    wr(2'd0, 16'h0000);
    rd(2'd0, r); chk("R11 zero write kept", {15'd0, r[1]}, 16'd1);
    wr(2'd1, 16'h0020);
    step(2);
    rd(2'd0, r); chk("R11 release cleared", {15'd0, r[1]}, 16'd0);
    chk("R11 sci off", {15'd0, sci_out}, 16'd0);

    // R12 command port
    wr(2'd2, 16'h0010);
    wr(2'd0, 16'h0101);
    foreach (cmds[i]) begin
      wr(2'd1, 16'h003F);
      step(2);
      wr(2'd3, {8'hFF, cmds[i]});
      step(3);
      rd(2'd3, r); chk("R12 cmd readback", r, {8'h00, cmds[i]});
      rd(2'd1, r); chk("R12 sw status", {15'd0, r[4]}, 16'd1);
      chk("R12 sw smi", {15'd0, smi_out}, 16'd1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule